// File: doc/BRIEF.md
# Register-Constant ALU Execute Unit

This block is the arithmetic and logic execute stage of a small 8-bit processor that has no accumulator and uses 18-bit instruction words. Each accepted instruction names a destination register in a 16-entry register file. Its second operand is either an 8-bit constant carried in the instruction or the contents of a second register. The unit computes the result, writes it back to the destination, and updates a zero flag and a carry flag. Two operations touch only the flags: a bitwise test and a compare.

The instruction word is split into three fields. The operation code sits in bits [17:12], the destination register index in [11:8], and the operand field in [7:0]. Bit 12, the lowest opcode bit, selects the kind of second operand. When it is 0, the operand field is the constant. When it is 1, bits [7:4] of the field name the source register and bits [3:0] are ignored. An instruction takes effect on the rising clock edge at which the valid strobe is high. A combinational debug port reads any register at any time.

Top module: `alu_exec_unit`

## Requirements
- R1: A synchronous reset clears all 16 registers, the zero flag and the carry flag.
- R2: While `instr_valid` is low, no register and no flag changes, whatever the instruction word holds.
- R3: Opcode bit 12 = 0 uses `instr[7:0]` as the constant operand. Opcode bit 12 = 1 uses the register indexed by `instr[7:4]`, and `instr[3:0]` has no effect.
- R4: Opcode class `instr[17:13]` = 00000 (LOAD) copies the operand into the destination and leaves both flags unchanged. LOAD of register 0 from register 0 (word 0x01000) changes nothing.
- R5: Classes 00101 (AND), 00110 (OR) and 00111 (XOR) write the bitwise result, clear carry, and set zero exactly when the result is 0.
- R6: Class 01001 (TEST) computes the AND without writing the destination, sets zero when that result is 0, and clears carry.
- R7: Class 01100 (ADD) writes (dest + operand) mod 256 and sets carry when the sum exceeds 255. Class 01101 (ADD with carry) also adds the current carry. Zero is set when the written byte is 0.
- R8: Class 01110 (SUB) writes (dest − operand) mod 256 and sets carry on borrow. Class 01111 (SUB with carry) also subtracts the current carry. Zero is set when the written byte is 0.
- R9: Class 01010 (COMPARE) writes nothing. It sets zero when operand equals the destination and sets carry when operand is greater than the destination.
- R10: Any other opcode class changes no register and no flag.
- R11: `dbg_data` shows the current contents of the register selected by `dbg_addr`, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Execute `instr` at this edge |
| instr | input | 18 | Instruction word: opcode, destination, operand field |
| dbg_addr | input | 4 | Register index for debug read |
| dbg_data | output | 8 | Contents of the selected register |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry flag |

## Verification
The carry-chained add and subtract are the hardest cases to reach from the ports. They need a chosen carry value going in, together with chosen operand values, and the carry can only be set by an earlier instruction. Before every operation, the bench first loads the destination and source registers with constants. It then issues a compare of a register held at zero against a constant 0 or 1, which forces carry to the wanted value. Only then does it issue the operation under test. This is swept over both operand kinds, both carry values and a grid of operand values, including the case where the source and destination registers are the same.

// File: rtl/alu_exec_unit.sv
module alu_exec_unit #(
  parameter int DATA_W  = 8,
  parameter int RADDR_W = 4,
  parameter int OPC_W   = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              instr_valid,
  input  logic [OPC_W+RADDR_W+DATA_W-1:0]   instr,
  input  logic [RADDR_W-1:0]                dbg_addr,
  output logic [DATA_W-1:0]                 dbg_data,
  output logic                              zero_flag,
  output logic                              carry_flag
);
  localparam int INSTR_W = OPC_W + RADDR_W + DATA_W;
  localparam int NREG    = 1 << RADDR_W;
  localparam int CLS_W   = OPC_W - 1;

  localparam logic [CLS_W-1:0] C_LOAD = 5'b00000;
  localparam logic [CLS_W-1:0] C_AND  = 5'b00101;
  localparam logic [CLS_W-1:0] C_OR   = 5'b00110;
  localparam logic [CLS_W-1:0] C_XOR  = 5'b00111;
  localparam logic [CLS_W-1:0] C_TEST = 5'b01001;
  localparam logic [CLS_W-1:0] C_CMP  = 5'b01010;
  localparam logic [CLS_W-1:0] C_ADD  = 5'b01100;
  localparam logic [CLS_W-1:0] C_ADDC = 5'b01101;
  localparam logic [CLS_W-1:0] C_SUB  = 5'b01110;
  localparam logic [CLS_W-1:0] C_SUBC = 5'b01111;

  logic [DATA_W-1:0] regs [NREG];

  wire [CLS_W-1:0]   cls    = instr[INSTR_W-1 -: CLS_W];
  wire               use_rs = instr[DATA_W+RADDR_W];
  wire [RADDR_W-1:0] rd     = instr[DATA_W +: RADDR_W];
  wire [DATA_W-1:0]  field  = instr[DATA_W-1:0];
  wire [RADDR_W-1:0] rs     = field[DATA_W-1 -: RADDR_W];
  wire [DATA_W-1:0]  opa    = regs[rd];
  wire [DATA_W-1:0]  opb    = use_rs ? regs[rs] : field;

  logic [DATA_W:0] wide;
  logic            wr_en, upd_z, upd_c, c_next;

  always_comb begin
    wide   = '0;
    wr_en  = 1'b0;
    upd_z  = 1'b0;
    upd_c  = 1'b0;
    c_next = 1'b0;
    case (cls)
      C_LOAD: begin wide = {1'b0, opb}; wr_en = 1'b1; end
      C_AND:  begin wide = {1'b0, opa & opb}; wr_en = 1'b1; upd_z = 1'b1; upd_c = 1'b1; end
      C_OR:   begin wide = {1'b0, opa | opb}; wr_en = 1'b1; upd_z = 1'b1; upd_c = 1'b1; end
      C_XOR:  begin wide = {1'b0, opa ^ opb}; wr_en = 1'b1; upd_z = 1'b1; upd_c = 1'b1; end
      C_TEST: begin wide = {1'b0, opa & opb}; upd_z = 1'b1; upd_c = 1'b1; end
      C_CMP: begin
        wide = {1'b0, opa} - {1'b0, opb};
        upd_z = 1'b1; upd_c = 1'b1; c_next = wide[DATA_W];
      end
      C_ADD, C_ADDC: begin
        wide = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, (cls == C_ADDC) & carry_flag};
        wr_en = 1'b1; upd_z = 1'b1; upd_c = 1'b1; c_next = wide[DATA_W];
      end
      C_SUB, C_SUBC: begin
        wide = {1'b0, opa} - {1'b0, opb} - {{DATA_W{1'b0}}, (cls == C_SUBC) & carry_flag};
        wr_en = 1'b1; upd_z = 1'b1; upd_c = 1'b1; c_next = wide[DATA_W];
      end
      default: ;
    endcase
  end

  wire [DATA_W-1:0] result = wide[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
    end else if (instr_valid) begin
      if (wr_en) regs[rd] <= result;
      if (upd_z) zero_flag <= (result == '0);
      if (upd_c) carry_flag <= c_next;
    end
  end

  assign dbg_data = regs[dbg_addr];

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(zero_flag) && $stable(carry_flag));

  p_load_flags_r4: assert property (@(posedge clk) disable iff (rst)
    instr_valid && cls == C_LOAD |=> $stable(zero_flag) && $stable(carry_flag));

  p_logic_carry_r5: assert property (@(posedge clk) disable iff (rst)
    instr_valid && (cls == C_AND || cls == C_OR || cls == C_XOR) |=> !carry_flag);

  p_test_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    instr_valid && cls == C_TEST |=> !carry_flag && regs[$past(rd)] == $past(opa));

  p_cmp_equal_r9: assert property (@(posedge clk) disable iff (rst)
    instr_valid && cls == C_CMP |=> zero_flag == $past(opa == opb));

  p_cmp_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    instr_valid && cls == C_CMP |=> regs[$past(rd)] == $past(opa));

  p_undef_hold_r10: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !wr_en && !upd_z |=> $stable(zero_flag) && $stable(carry_flag));
endmodule

// File: tb/sim_alu_exec_unit.sv
`timescale 1ns/100ps
module sim_alu_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [17:0] instr = '0;
  logic [3:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;
  logic        zero_flag, carry_flag;

  int n_run = 0, n_fail = 0;
  int ref_regs [16];
  bit ref_z = 0, ref_c = 0;

  always #10 clk = ~clk;

  alu_exec_unit u0 (.clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .zero_flag(zero_flag), .carry_flag(carry_flag));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < 16; r++) begin
      dbg_addr = r[3:0];
      #0.5;
      chk(tag, dbg_data, ref_regs[r]);
    end
    chk(tag, zero_flag, ref_z);
    chk(tag, carry_flag, ref_c);
  endtask

  task automatic issue(input logic [5:0] op, input int rd, input logic [7:0] fld);
    int a, b, s, r;
    string tag;
    @(negedge clk);
    instr = {op, rd[3:0], fld};
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    a = ref_regs[rd];
    b = op[0] ? ref_regs[fld[7:4]] : int'(fld);
    case (op[5:1])
      5'b00000: begin tag = "R4"; ref_regs[rd] = b; end
      5'b00101: begin tag = "R5"; r = a & b; ref_regs[rd] = r; ref_c = 0; ref_z = (r == 0); end
      5'b00110: begin tag = "R5"; r = a | b; ref_regs[rd] = r; ref_c = 0; ref_z = (r == 0); end
      5'b00111: begin tag = "R5"; r = a ^ b; ref_regs[rd] = r; ref_c = 0; ref_z = (r == 0); end
      5'b01001: begin tag = "R6"; r = a & b; ref_c = 0; ref_z = (r == 0); end
      5'b01010: begin tag = "R9"; ref_z = (a == b); ref_c = (b > a); end
      5'b01100, 5'b01101: begin
        tag = "R7";
        s = a + b + ((op[1] && ref_c) ? 1 : 0);
        ref_regs[rd] = s & 255; ref_c = (s > 255); ref_z = ((s & 255) == 0);
      end
      5'b01110, 5'b01111: begin
        tag = "R8";
        s = a - b - ((op[1] && ref_c) ? 1 : 0);
        ref_regs[rd] = s & 255; ref_c = (s < 0); ref_z = ((s & 255) == 0);
      end
      default: tag = "R10";
    endcase
    dbg_addr = rd[3:0];
    #0.5;
    chk(tag, dbg_data, ref_regs[rd]);
    chk(tag, zero_flag, ref_z);
    chk(tag, carry_flag, ref_c);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] classes [10];
    classes = '{5'b00000, 5'b00101, 5'b00110, 5'b00111, 5'b01001,
                5'b01010, 5'b01100, 5'b01101, 5'b01110, 5'b01111};
    for (int i = 0; i < 16; i++) ref_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweep("R1");

    // R11: distinct values in every register, read back combinationally
    for (int i = 0; i < 16; i++) issue(6'b000000, i, 8'(i * 37 + 5));
    sweep("R11");

    // R3: register source from field[7:4], low nibble ignored
    issue(6'b000001, 3, 8'h5A);
    issue(6'b000001, 4, 8'h50);
    dbg_addr = 4'd3; #0.5; chk("R3", dbg_data, ref_regs[5]);
    issue(6'b000000, 6, 8'h5A);
    dbg_addr = 4'd6; #0.5; chk("R3", dbg_data, 8'h5A);

    // R4: NOP word leaves everything unchanged
    issue(6'b000001, 0, 8'h00);
    sweep("R4");

    // R2: valid low holds state
    @(negedge clk);
    instr = {6'b011000, 4'd1, 8'hFF};
    repeat (5) @(negedge clk);
    sweep("R2");

    // R10: every undefined class with both operand kinds
    for (int op = 0; op < 64; op++) begin
      logic [4:0] c5;
      bit known;
      c5 = op[5:1];
      known = 0;
      for (int k = 0; k < 10; k++) if (classes[k] == c5) known = 1;
      if (!known) begin
        issue(op[5:0], op % 16, 8'(op * 11));
        sweep("R10");
      end
    end

    // R1 again: reset mid-run
    issue(6'b011000, 7, 8'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) ref_regs[i] = 0;
    ref_z = 0; ref_c = 0;
    sweep("R1");

    // Main sweep; r15 stays 0 and is used to force carry
    for (int k = 0; k < 10; k++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 256; a += 17)
          for (int b = 0; b < 256; b += 15)
            for (int cin = 0; cin < 2; cin++) begin
              issue(6'b000000, 1, 8'(a));
              issue(6'b000000, 2, 8'(b));
              issue(6'b010100, 15, 8'(cin));
              issue({classes[k], m[0]}, 1, m ? 8'h29 : 8'(b));
            end

    // Same register as source and destination, with carry in
    for (int k = 0; k < 10; k++)
      for (int cin = 0; cin < 2; cin++) begin
        issue(6'b000000, 9, 8'hC3);
        issue(6'b010100, 15, 8'(cin));
        issue({classes[k], 1'b1}, 9, 8'h9F);
      end
    sweep("R3");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule